// File: doc/BRIEF.md
# Byte-Sectioned Host Register Port

This block is the host-facing front end of a register file. The registers it serves are 8, 16 or 24 bits wide, and the host reaches them over an 8-bit data bus. Each wide register is cut into byte sections. Every section has its own address and takes its own bus cycle. A write to a wide register is staged in a shadow and takes effect as one word. A read starts at the low section, which freezes a coherent copy of the whole word for the sections that follow.

A strap input selects parallel or serial host access. It is sampled only while a qualified reset is in force, and a reset only takes effect after it has been held for a minimum number of cycles. After reset the port refuses every access until a wake-up interval has elapsed. Some register groups depend on a processing clock. While a clock-present input reports that clock as missing, accesses to those groups are refused and recorded in a status flag. The serial protocol engine lives elsewhere and receives only the mode indication.

Top module: `sect_host_port`

## Requirements
- R1: The address `bus_addr[5:0]` is laid out as follows.
  - Bits [5:4] hold a group code: 0 to 3 stand for groups 1 to 4.
  - Bits [3:2] hold a slot: slots 0, 1 and 2 are 8, 16 and 24 bits wide, and slot 3 is unmapped.
  - Bits [1:0] hold a section: 0 is the LSB, 1 the middle byte and 2 the MSB.
  - A section at or beyond the width of its slot is unmapped. Writes to unmapped addresses are ignored and reads of them return 0.
- R2: A write to a section below a register's top section goes only to a shadow. A write to the top section commits the shadow bytes and the new byte to the register together. Until that commit, reads return the previous value.
- R3: A read of section 0 returns the low byte and snapshots the upper bytes. Later reads of sections 1 and 2 return that snapshot, even if the register has been rewritten since.
- R4: Every read strobe (`bus_sel` high, `bus_wr` low) gives `rd_valid` high with `rd_data` one clock later. A write strobe gives `rd_valid` low.
- R5: `mode_strap` is sampled while the reset is in effect: 1 selects parallel mode and 0 selects serial mode, and the result is shown on `host_parallel`. Changes of the strap outside reset have no effect.
- R6: A reset takes effect only on the third consecutive cycle in which `rst` is high. A shorter pulse leaves the mode, the ready state and the register contents unchanged.
- R7: `ready` is low after reset and goes high after the 280th clock edge at which `rst` is low.
- R8: Accesses made while `ready` is low are ignored and reads return 0. They also set `early_err`, which stays set until the next effective reset.
- R9: While `clk_present` is low, accesses to groups 2 and 3 (codes 1 and 2) are ignored, reads return 0, and `clk_reject` is set and stays set until reset. Groups 1 and 4 are served regardless of `clk_present`.
- R10: In serial mode, bus accesses are ignored and reads return 0, and neither flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, which also paces the wake-up interval |
| rst | input | 1 | Synchronous active-high reset request |
| mode_strap | input | 1 | Host mode strap, sampled during reset |
| clk_present | input | 1 | High while the processing clock runs |
| bus_sel | input | 1 | Access strobe, one cycle per section |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Group, slot and section address |
| bus_wdata | input | 8 | Write byte |
| rd_data | output | 8 | Registered read byte |
| rd_valid | output | 1 | Read byte valid |
| host_parallel | output | 1 | Latched host mode, 1 = parallel |
| ready | output | 1 | Wake-up interval over |
| early_err | output | 1 | Sticky: access attempted before ready |
| clk_reject | output | 1 | Sticky: clock-dependent access refused |

## Verification
The bench writes the lower sections of a 24-bit register without the top section and reads the register back. A design that committed each section as it arrived would show a mixed value. It then rewrites the register between an LSB read and the upper-section reads, which exposes a design that reads the live word instead of a snapshot. It also pulses reset for only two cycles, tries accesses during the wake-up window, and touches clock-dependent groups with the clock absent. A design that honoured short pulses, accepted early writes or served a stopped group would return the stale or forbidden byte. Finally it swaps the strap after reset and runs in serial mode, where a design that tracked the live strap would change mode.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int BYTE_W = 8;
  localparam int SECT_W = 2;

  typedef enum logic [2:0] {
    ACC_IDLE,
    ACC_OK,
    ACC_EARLY,
    ACC_SERIAL,
    ACC_NOCLK,
    ACC_UNMAPPED
  } acc_verdict_e;
endpackage

// File: rtl/sreg_boot.sv
// Reset qualification, host mode latch and wake-up counter.
module sreg_boot #(
  parameter int WAKE_CYCLES = 280,
  parameter int RST_MIN     = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic strap,
  output logic rst_eff,
  output logic mode_par,
  output logic ready
);
  localparam int RC_W  = $clog2(RST_MIN + 1);
  localparam int CNT_W = $clog2(WAKE_CYCLES + 1);

  logic [RC_W-1:0]  held_q = '0;
  logic [CNT_W-1:0] wake_q;

  // count consecutive cycles with rst high, saturating
  always_ff @(posedge clk) begin
    if (!rst)
      held_q <= '0;
    else if (held_q < RC_W'(RST_MIN - 1))
      held_q <= held_q + 1'b1;
  end

  assign rst_eff = rst && (held_q >= RC_W'(RST_MIN - 1));

  always_ff @(posedge clk) begin
    if (rst_eff)
      mode_par <= strap;
  end

  always_ff @(posedge clk) begin
    if (rst_eff) begin
      wake_q <= '0;
      ready  <= 1'b0;
    end else if (!rst && !ready) begin
      wake_q <= wake_q + 1'b1;
      if (wake_q == CNT_W'(WAKE_CYCLES - 1))
        ready <= 1'b1;
    end
  end
endmodule

// File: rtl/sreg_decode.sv
// Splits a bus address into register index, section and attributes.
module sreg_decode #(
  parameter int GROUPS    = 4,
  parameter int SLOTS     = 3,
  parameter int SLOT_W    = 2,
  parameter int MAX_BYTES = 3,
  parameter logic [GROUPS-1:0] CLKDEP_MASK = 'b0110,
  localparam int GRP_W  = $clog2(GROUPS),
  localparam int ADDR_W = GRP_W + SLOT_W + sreg_pkg::SECT_W,
  localparam int REGS   = GROUPS * SLOTS,
  localparam int IDX_W  = $clog2(REGS),
  localparam int NB_W   = $clog2(MAX_BYTES + 1)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic              top,
  output logic              clk_dep,
  output logic [IDX_W-1:0]  idx,
  output logic [sreg_pkg::SECT_W-1:0] sect,
  output logic [NB_W-1:0]   nbytes
);
  import sreg_pkg::*;

  logic [GRP_W-1:0]  grp;
  logic [SLOT_W-1:0] slot;
  int                nb_i;

  assign grp  = addr[ADDR_W-1 -: GRP_W];
  assign slot = addr[SECT_W +: SLOT_W];
  assign sect = addr[SECT_W-1:0];

  always_comb begin
    nb_i = (int'(slot) % MAX_BYTES) + 1;
    nbytes  = NB_W'(nb_i);
    idx     = IDX_W'(int'(grp) * SLOTS + int'(slot));
    clk_dep = CLKDEP_MASK[grp];
    hit     = (int'(grp) < GROUPS) && (int'(slot) < SLOTS) && (int'(sect) < nb_i);
    top     = (int'(sect) == nb_i - 1);
  end
endmodule

// File: rtl/sreg_store.sv
// Register words, write shadow and read snapshot.
module sreg_store #(
  parameter int REGS      = 12,
  parameter int MAX_BYTES = 3,
  localparam int IDX_W  = $clog2(REGS),
  localparam int NB_W   = $clog2(MAX_BYTES + 1),
  localparam int WORD_W = MAX_BYTES * sreg_pkg::BYTE_W,
  localparam int LOW_W  = (MAX_BYTES - 1) * sreg_pkg::BYTE_W
) (
  input  logic                 clk,
  input  logic                 rst_eff,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic                 rd_any,
  input  logic [IDX_W-1:0]     idx,
  input  logic [sreg_pkg::SECT_W-1:0] sect,
  input  logic [NB_W-1:0]      nbytes,
  input  logic                 top,
  input  logic [sreg_pkg::BYTE_W-1:0] wdata,
  output logic [sreg_pkg::BYTE_W-1:0] rd_byte
);
  import sreg_pkg::*;

  logic [WORD_W-1:0] mem [REGS];
  logic [WORD_W-1:0] word_rd;
  logic [WORD_W-1:0] commit_word;
  logic [LOW_W-1:0]  shadow_q;
  logic [LOW_W-1:0]  snap_q;
  logic [BYTE_W-1:0] sel_byte;

  assign word_rd = mem[idx];

  // build the committed word byte by byte
  for (genvar b = 0; b < MAX_BYTES; b++) begin : g_commit
    if (b < MAX_BYTES - 1) begin : g_low
      assign commit_word[b*BYTE_W +: BYTE_W] =
        (int'(nbytes) == b + 1) ? wdata :
        (int'(nbytes) >  b + 1) ? shadow_q[b*BYTE_W +: BYTE_W] : '0;
      always_ff @(posedge clk) begin
        if (rst_eff)
          shadow_q[b*BYTE_W +: BYTE_W] <= '0;
        else if (wr_en && !top && int'(sect) == b)
          shadow_q[b*BYTE_W +: BYTE_W] <= wdata;
      end
    end else begin : g_high
      assign commit_word[b*BYTE_W +: BYTE_W] =
        (int'(nbytes) == b + 1) ? wdata : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && top)
      mem[idx] <= commit_word;
  end

  always_comb begin
    sel_byte = word_rd[BYTE_W-1:0];
    for (int b = 1; b < MAX_BYTES; b++)
      if (int'(sect) == b)
        sel_byte = snap_q[(b-1)*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (rst_eff) begin
      snap_q  <= '0;
      rd_byte <= '0;
    end else begin
      if (rd_en && sect == '0)
        snap_q <= word_rd[WORD_W-1:BYTE_W];
      if (rd_any)
        rd_byte <= rd_en ? sel_byte : '0;
    end
  end
endmodule

// File: rtl/sect_host_port.sv
// Byte-sectioned host register port: top level.
module sect_host_port #(
  parameter int GROUPS      = 4,
  parameter int SLOTS       = 3,
  parameter int SLOT_W      = 2,
  parameter int MAX_BYTES   = 3,
  parameter int WAKE_CYCLES = 280,
  parameter int RST_MIN     = 3,
  parameter logic [GROUPS-1:0] CLKDEP_MASK = 'b0110,
  localparam int GRP_W  = $clog2(GROUPS),
  localparam int ADDR_W = GRP_W + SLOT_W + sreg_pkg::SECT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_strap,
  input  logic              clk_present,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  output logic              host_parallel,
  output logic              ready,
  output logic              early_err,
  output logic              clk_reject
);
  import sreg_pkg::*;

  localparam int REGS  = GROUPS * SLOTS;
  localparam int IDX_W = $clog2(REGS);
  localparam int NB_W  = $clog2(MAX_BYTES + 1);

  logic             rst_eff;
  logic             mode_par;
  logic             hit, top, clk_dep;
  logic [IDX_W-1:0] idx;
  logic [SECT_W-1:0] sect;
  logic [NB_W-1:0]  nbytes;
  acc_verdict_e     verdict;
  logic             accept, wr_en, rd_en, rd_any;

  sreg_boot #(
    .WAKE_CYCLES(WAKE_CYCLES),
    .RST_MIN    (RST_MIN)
  ) i_boot (
    .clk     (clk),
    .rst     (rst),
    .strap   (mode_strap),
    .rst_eff (rst_eff),
    .mode_par(mode_par),
    .ready   (ready)
  );

  sreg_decode #(
    .GROUPS     (GROUPS),
    .SLOTS      (SLOTS),
    .SLOT_W     (SLOT_W),
    .MAX_BYTES  (MAX_BYTES),
    .CLKDEP_MASK(CLKDEP_MASK)
  ) i_dec (
    .addr   (bus_addr),
    .hit    (hit),
    .top    (top),
    .clk_dep(clk_dep),
    .idx    (idx),
    .sect   (sect),
    .nbytes (nbytes)
  );

  // access verdict, in priority order
  always_comb begin
    if (!bus_sel)                    verdict = ACC_IDLE;
    else if (!ready)                 verdict = ACC_EARLY;
    else if (!mode_par)              verdict = ACC_SERIAL;
    else if (clk_dep && !clk_present) verdict = ACC_NOCLK;
    else if (!hit)                   verdict = ACC_UNMAPPED;
    else                             verdict = ACC_OK;
  end

  assign accept = (verdict == ACC_OK);
  assign wr_en  = accept && bus_wr;
  assign rd_en  = accept && !bus_wr;
  assign rd_any = bus_sel && !bus_wr;

  sreg_store #(
    .REGS     (REGS),
    .MAX_BYTES(MAX_BYTES)
  ) i_store (
    .clk    (clk),
    .rst_eff(rst_eff),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .rd_any (rd_any),
    .idx    (idx),
    .sect   (sect),
    .nbytes (nbytes),
    .top    (top),
    .wdata  (bus_wdata),
    .rd_byte(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst_eff) begin
      rd_valid   <= 1'b0;
      early_err  <= 1'b0;
      clk_reject <= 1'b0;
    end else begin
      rd_valid <= rd_any;
      if (verdict == ACC_EARLY) early_err  <= 1'b1;
      if (verdict == ACC_NOCLK) clk_reject <= 1'b1;
    end
  end

  assign host_parallel = mode_par;
endmodule

// File: rtl/sect_host_port_chk.sv
// Property checker for sect_host_port, attached by bind.
module sect_host_port_chk #(
  parameter int ADDR_W = 6,
  parameter int GRP_W  = 2,
  parameter int GROUPS = 4,
  parameter logic [GROUPS-1:0] CLKDEP_MASK = 'b0110
) (
  input logic              clk,
  input logic              rst,
  input logic              clk_present,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        rd_data,
  input logic              rd_valid,
  input logic              host_parallel,
  input logic              ready,
  input logic              early_err,
  input logic              clk_reject
);
  logic grp_dep;
  assign grp_dep = CLKDEP_MASK[bus_addr[ADDR_W-1 -: GRP_W]];

  // R5
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(host_parallel));

  // R4
  rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_wr) |=> rd_valid);

  // R4
  no_spurious_rd_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && !bus_wr) |=> !rd_valid);

  // R7
  ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> !$fell(ready));

  // R8
  early_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !ready) |=> early_err);

  // R8
  early_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_wr && !ready) |=> (rd_data == 8'h00));

  // R9
  noclk_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && ready && host_parallel && grp_dep && !clk_present) |=> clk_reject);

  // R10
  serial_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_wr && ready && !host_parallel) |=> (rd_data == 8'h00));
endmodule

bind sect_host_port sect_host_port_chk #(
  .ADDR_W     (ADDR_W),
  .GRP_W      (GRP_W),
  .GROUPS     (GROUPS),
  .CLKDEP_MASK(CLKDEP_MASK)
) i_chk (
  .clk          (clk),
  .rst          (rst),
  .clk_present  (clk_present),
  .bus_sel      (bus_sel),
  .bus_wr       (bus_wr),
  .bus_addr     (bus_addr),
  .rd_data      (rd_data),
  .rd_valid     (rd_valid),
  .host_parallel(host_parallel),
  .ready        (ready),
  .early_err    (early_err),
  .clk_reject   (clk_reject)
);

// File: tb/test_sect_host_port.sv
module test_sect_host_port;
  localparam int CLK_PERIOD = 10;
  localparam int WAKE       = 280;

  typedef struct {
    string      req;
    logic [7:0] val;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_strap = 1'b1;
  logic       clk_present = 1'b1;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] rd_data;
  logic       rd_valid, host_parallel, ready, early_err, clk_reject;

  int   tests = 0;
  int   fails = 0;
  bit   done  = 1'b0;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sect_host_port i_sect_host_port (
    .clk(clk), .rst(rst), .mode_strap(mode_strap), .clk_present(clk_present),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_data(rd_data), .rd_valid(rd_valid), .host_parallel(host_parallel),
    .ready(ready), .early_err(early_err), .clk_reject(clk_reject)
  );

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: compares every returned byte against the scoreboard
  always @(negedge clk) begin
    if (!done && rd_valid) begin
      if (sb_q.size() == 0) begin
        tests++; fails++;
        $display("FAIL R4: unexpected read byte actual %0h expected none", rd_data);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(e.req, rd_data, e.val);
      end
    end
  end

  task automatic access(bit w, logic [5:0] a, logic [7:0] d);
    bus_sel = 1'b1; bus_wr = w; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic wr(logic [5:0] a, logic [7:0] d);
    access(1'b1, a, d);
  endtask

  task automatic rd(logic [5:0] a, logic [7:0] exp, string req);
    exp_t e;
    e.req = req; e.val = exp;
    sb_q.push_back(e);
    access(1'b0, a, 8'h00);
  endtask

  task automatic do_reset(int cycles, bit strap);
    rst = 1'b1; mode_strap = strap;
    repeat (cycles) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < WAKE + 10 && !ready; i++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // reset state and wake-up timing
    do_reset(4, 1'b1);
    chk("R7 ready low after reset", ready, 0);
    chk("R5 parallel mode latched", host_parallel, 1);
    chk("R8 early_err clear", early_err, 0);
    chk("R9 clk_reject clear", clk_reject, 0);
    repeat (WAKE - 1) @(posedge clk);
    @(negedge clk);
    chk("R7 ready still low at edge WAKE-1", ready, 0);
    @(posedge clk);
    @(negedge clk);
    chk("R7 ready high after WAKE edges", ready, 1);

    // 24-bit register, group 1 slot 2
    wr(6'h08, 8'h01); wr(6'h09, 8'h02); wr(6'h0A, 8'h03);
    chk("R4 no rd_valid after write", rd_valid, 0);
    rd(6'h08, 8'h01, "R3 lsb"); rd(6'h09, 8'h02, "R3 mid"); rd(6'h0A, 8'h03, "R3 msb");
    wr(6'h08, 8'hA1); wr(6'h09, 8'hB2);
    rd(6'h08, 8'h01, "R2 no commit before msb");
    wr(6'h0A, 8'hC3);
    rd(6'h08, 8'hA1, "R2 commit lsb"); rd(6'h09, 8'hB2, "R2 commit mid");
    rd(6'h0A, 8'hC3, "R2 commit msb");
    // snapshot coherence
    rd(6'h08, 8'hA1, "R3 snapshot lsb");
    wr(6'h08, 8'h11); wr(6'h09, 8'h22); wr(6'h0A, 8'h33);
    rd(6'h09, 8'hB2, "R3 snapshot mid held"); rd(6'h0A, 8'hC3, "R3 snapshot msb held");
    rd(6'h08, 8'h11, "R3 new lsb"); rd(6'h09, 8'h22, "R3 new mid");
    rd(6'h0A, 8'h33, "R3 new msb");

    // 16-bit register, group 4 slot 1, and its unmapped third section
    wr(6'h34, 8'h5A); wr(6'h35, 8'h6B);
    wr(6'h36, 8'hFF);
    rd(6'h34, 8'h5A, "R1 16-bit lsb"); rd(6'h35, 8'h6B, "R1 16-bit msb");
    rd(6'h36, 8'h00, "R1 section beyond width");
    // 8-bit register, group 1 slot 0
    wr(6'h00, 8'h11); wr(6'h01, 8'h77);
    rd(6'h00, 8'h11, "R1 8-bit reg"); rd(6'h01, 8'h00, "R1 8-bit unmapped mid");
    wr(6'h0C, 8'h99);
    rd(6'h0C, 8'h00, "R1 slot 3 unmapped");

    // clock-dependent groups
    wr(6'h10, 8'h42);
    rd(6'h10, 8'h42, "R9 group 2 with clock");
    clk_present = 1'b0;
    wr(6'h10, 8'h99);
    rd(6'h10, 8'h00, "R9 group 2 without clock");
    rd(6'h20, 8'h00, "R9 group 3 without clock");
    chk("R9 clk_reject set", clk_reject, 1);
    wr(6'h30, 8'h3C);
    rd(6'h30, 8'h3C, "R9 group 4 without clock");
    rd(6'h00, 8'h11, "R9 group 1 without clock");
    clk_present = 1'b1;
    rd(6'h10, 8'h42, "R9 blocked write ignored");

    // short reset pulse
    do_reset(2, 1'b0);
    @(negedge clk);
    chk("R6 mode kept after short pulse", host_parallel, 1);
    chk("R6 ready kept after short pulse", ready, 1);
    chk("R6 flag kept after short pulse", clk_reject, 1);
    rd(6'h00, 8'h11, "R6 contents kept");

    // early access during wake-up; strap changes after reset
    do_reset(4, 1'b1);
    mode_strap = 1'b0;
    chk("R9 clk_reject cleared by reset", clk_reject, 0);
    wr(6'h00, 8'h55);
    rd(6'h00, 8'h00, "R8 early read returns 0");
    chk("R8 early_err set", early_err, 1);
    wait_ready();
    chk("R8 early_err sticky", early_err, 1);
    chk("R5 strap change ignored", host_parallel, 1);
    rd(6'h00, 8'h11, "R8 early write ignored");

    // serial mode
    do_reset(4, 1'b0);
    chk("R8 early_err cleared by reset", early_err, 0);
    chk("R5 serial mode latched", host_parallel, 0);
    wait_ready();
    wr(6'h00, 8'hEE);
    rd(6'h00, 8'h00, "R10 serial read returns 0");
    chk("R10 no early_err", early_err, 0);
    chk("R10 no clk_reject", clk_reject, 0);
    do_reset(4, 1'b1);
    wait_ready();
    rd(6'h00, 8'h11, "R10 serial write ignored");

    @(negedge clk);
    chk("R4 all reads returned", sb_q.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule